// File: doc/BRIEF.md
# Dual Timer Register Wrapper

This block puts two independent down-counting timer channels behind a single 4 KB register window on a 32-bit APB-style slave port. It decodes each access to a channel or to a small system area. The system area holds an integration-test switch that lets software force the interrupt lines, plus a read-only identification window. The block drives one registered interrupt line per channel and a combined line that is the OR of the per-channel lines.

Reads complete in the access phase with no wait states. Writes take effect on the clock edge where select, enable and write are all high. Unmapped offsets read as zero, and writes to them change nothing. Narrow accesses are treated as full words: the byte strobes are ignored, and whatever is on the write data bus is stored.

Top module: `dtw_wrap`

## Requirements
- R1: Channel n (n = 0, 1) decodes at byte offset n*0x20. Its word offsets are:
  - 0x00 load (reads the reload value)
  - 0x04 current count
  - 0x08 control
  - 0x0C interrupt clear (write-only, reads 0)
  - 0x10 raw status in bit 0
  - 0x14 masked status in bit 0
  - 0x18 background load (reads the reload value)
  The two channels operate independently.
- R2: A write to a channel's load offset sets both the reload value and the current count. A write to its background load offset sets only the reload value.
- R3: Control has four bits: bit 7 run, bit 6 periodic reload, bit 5 interrupt enable and bit 0 one-shot. All other bits are ignored on write and read 0. The reset value is 0x20.
- R4: The current count resets to 0xFFFFFFFF and the reload value to 0. While running, the count decrements once per clock. The step from 1 to 0 sets raw status. Masked status is raw AND interrupt enable. A write to interrupt clear resets raw status.
- R5: Test control is bit 0 at 0xF00 and reads back. Test output is bits [1:0] at 0xF04 and is write-only, reading 0. While test control is 1, channel 0's interrupt line follows test output bit 0 and channel 1's follows bit 1, each one clock after the register.
- R6: The combined interrupt output always equals the OR of the per-channel interrupt outputs.
- R7: The twelve words at 0xFD0..0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R8: Unmapped offsets read as zero and ignore writes. These include 0x1C in a channel, channel indices of 2 and above, and system offsets other than 0xF00, 0xF04 and the identification words.
- R9: The byte strobes are ignored. Every write stores the full write data word.
- R10: After reset, both test registers are 0, the interrupt lines are low, and in normal mode each interrupt line follows its channel's masked status one clock later.
- R11: Ready is always high and the error response is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes (ignored) |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer ready, tied high |
| pslverr | output | 1 | Error response, tied low |
| irq_ch | output | 2 | Per-channel interrupt lines, registered |
| irq_comb | output | 1 | OR of the per-channel lines |

## Verification
The assertions assume a well-formed two-phase bus protocol:
- a setup cycle with select high and enable low, then exactly one access cycle with both high;
- address and data held steady across both phases;
- reset asserted before the first clock edge.

The stimulus meets these assumptions by moving inputs only on falling edges, always issuing complete setup/access pairs, and holding reset high from time zero. The test-mode assertion further assumes that the test output register is written only through its own offset. The stimulus writes it only there.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  typedef enum logic [2:0] {
    CR_LOAD  = 3'd0,
    CR_VALUE = 3'd1,
    CR_CTRL  = 3'd2,
    CR_ICLR  = 3'd3,
    CR_RAW   = 3'd4,
    CR_MSK   = 3'd5,
    CR_BGLD  = 3'd6,
    CR_NONE  = 3'd7
  } chan_reg_e;

  localparam int CTRL_W       = 8;
  localparam int CTRL_RUN     = 7;
  localparam int CTRL_PERIOD  = 6;
  localparam int CTRL_IEN     = 5;
  localparam int CTRL_ONESHOT = 0;
  localparam logic [CTRL_W-1:0] CTRL_KEEP  = 8'hE1;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;
  localparam int ID_WORDS = 12;
endpackage

// File: rtl/dtw_channel.sv
module dtw_channel
  import dtw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  chan_reg_e         sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_masked
);
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] count_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              raw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count_q  <= '1;
      ctrl_q   <= CTRL_RESET;
      raw_q    <= 1'b0;
    end else begin
      if (ctrl_q[CTRL_RUN]) begin
        if (count_q != '0) begin
          count_q <= count_q - 1'b1;
          if (count_q == DATA_W'(1)) raw_q <= 1'b1;
        end else if (!ctrl_q[CTRL_ONESHOT]) begin
          count_q <= ctrl_q[CTRL_PERIOD] ? reload_q : '1;
        end
      end
      if (wr_en) begin
        case (sel)
          CR_LOAD: begin
            reload_q <= wdata;
            count_q  <= wdata;
          end
          CR_BGLD: reload_q <= wdata;
          CR_CTRL: ctrl_q   <= wdata[CTRL_W-1:0] & CTRL_KEEP;
          CR_ICLR: raw_q    <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign irq_masked = raw_q & ctrl_q[CTRL_IEN];

  always_comb begin
    rdata = '0;
    case (sel)
      CR_LOAD, CR_BGLD: rdata = reload_q;
      CR_VALUE:         rdata = count_q;
      CR_CTRL:          rdata = DATA_W'(ctrl_q);
      CR_RAW:           rdata = DATA_W'(raw_q);
      CR_MSK:           rdata = DATA_W'(irq_masked);
      default:          rdata = '0;
    endcase
  end
endmodule

// File: rtl/dtw_id_rom.sv
module dtw_id_rom (
  input  logic [3:0] idx,
  output logic [7:0] id_byte
);
  always_comb begin
    case (idx)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h23;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h1B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/dtw_irq_out.sv
module dtw_irq_out #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_en,
  input  logic [NUM_CH-1:0] test_bits,
  input  logic [NUM_CH-1:0] chan_irq,
  output logic [NUM_CH-1:0] irq_q,
  output logic              irq_any_q
);
  logic [NUM_CH-1:0] irq_d;

  assign irq_d = test_en ? test_bits : chan_irq;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q     <= '0;
      irq_any_q <= 1'b0;
    end else begin
      irq_q     <= irq_d;
      irq_any_q <= |irq_d;
    end
  end
endmodule

// File: rtl/dtw_wrap.sv
module dtw_wrap
  import dtw_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [3:0]        pstrb,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [NUM_CH-1:0] irq_ch,
  output logic              irq_comb
);
  localparam int WORD_W  = ADDR_W - 2;
  localparam int CHIDX_W = ADDR_W - 5;
  localparam logic [WORD_W-1:0] W_TCTL    = WORD_W'('hF00 >> 2);
  localparam logic [WORD_W-1:0] W_TOUT    = WORD_W'('hF04 >> 2);
  localparam logic [WORD_W-1:0] W_ID_BASE = WORD_W'('hFD0 >> 2);
  localparam logic [WORD_W-1:0] W_ID_LAST = W_ID_BASE + WORD_W'(ID_WORDS - 1);

  logic [WORD_W-1:0]  word;
  logic               in_sys;
  logic [CHIDX_W-1:0] ch_idx;
  chan_reg_e          ch_sel;
  logic               ch_hit;
  logic               wr_fire;
  logic               test_en_q;
  logic [NUM_CH-1:0]  test_bits_q;
  logic [NUM_CH-1:0]  ch_irq;
  logic [DATA_W-1:0]  ch_rd [NUM_CH];
  logic [DATA_W-1:0]  ch_rd_sel;
  logic               is_id;
  logic [WORD_W-1:0]  id_off;
  logic [7:0]         id_byte;
  logic               unused_ok;

  assign word    = paddr[ADDR_W-1:2];
  assign in_sys  = (paddr[ADDR_W-1:ADDR_W-4] == 4'hF);
  assign ch_idx  = paddr[ADDR_W-1:5];
  assign ch_sel  = chan_reg_e'(paddr[4:2]);
  assign ch_hit  = !in_sys && (int'(ch_idx) < NUM_CH) && (ch_sel != CR_NONE);
  assign wr_fire = psel && penable && pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign unused_ok = ^{pstrb, paddr[1:0]};

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dtw_channel #(.DATA_W(DATA_W)) u_ch (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_fire && ch_hit && (int'(ch_idx) == i)),
        .sel        (ch_sel),
        .wdata      (pwdata),
        .rdata      (ch_rd[i]),
        .irq_masked (ch_irq[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      test_en_q   <= 1'b0;
      test_bits_q <= '0;
    end else if (wr_fire && in_sys) begin
      if (word == W_TCTL) test_en_q   <= pwdata[0];
      if (word == W_TOUT) test_bits_q <= pwdata[NUM_CH-1:0];
    end
  end

  dtw_irq_out #(.NUM_CH(NUM_CH)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .test_en   (test_en_q),
    .test_bits (test_bits_q),
    .chan_irq  (ch_irq),
    .irq_q     (irq_ch),
    .irq_any_q (irq_comb)
  );

  assign is_id  = in_sys && (word >= W_ID_BASE) && (word <= W_ID_LAST);
  assign id_off = word - W_ID_BASE;

  dtw_id_rom u_id (
    .idx     (id_off[3:0]),
    .id_byte (id_byte)
  );

  always_comb begin
    ch_rd_sel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(ch_idx) == i) ch_rd_sel = ch_rd[i];
    end
  end

  always_comb begin
    prdata = '0;
    if (in_sys) begin
      if (word == W_TCTL) prdata = DATA_W'(test_en_q);
      else if (is_id)     prdata = DATA_W'(id_byte);
    end else if (ch_hit) begin
      prdata = ch_rd_sel;
    end
  end
endmodule

// File: rtl/dtw_wrap_chk.sv
module dtw_wrap_chk #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic [NUM_CH-1:0] irq_ch,
  input logic              irq_comb,
  input logic              test_en,
  input logic [NUM_CH-1:0] test_bits
);
  assert_comb_or_R6: assert property (@(posedge clk) disable iff (rst)
    irq_comb == (|irq_ch));

  assert_test_drive_R5: assert property (@(posedge clk) disable iff (rst)
    $past(test_en) |-> irq_ch == $past(test_bits));

  assert_tctl_write_R5: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pwrite && paddr == ADDR_W'('hF00)) |=> test_en == $past(pwdata[0]));

  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (!test_en && irq_ch == '0 && !irq_comb));

  assert_id_first_R7: assert property (@(posedge clk) disable iff (rst)
    (psel && !pwrite && paddr == ADDR_W'('hFD0)) |-> prdata == DATA_W'(32'h04));

  assert_id_last_R7: assert property (@(posedge clk) disable iff (rst)
    (psel && !pwrite && paddr == ADDR_W'('hFFC)) |-> prdata == DATA_W'(32'hB1));

  assert_hole_read_R8: assert property (@(posedge clk) disable iff (rst)
    (psel && !pwrite && paddr == ADDR_W'('h01C)) |-> prdata == '0);
endmodule

bind dtw_wrap dtw_wrap_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pwdata    (pwdata),
  .prdata    (prdata),
  .irq_ch    (irq_ch),
  .irq_comb  (irq_comb),
  .test_en   (test_en_q),
  .test_bits (test_bits_q)
);

// File: tb/tb_dtw_wrap.sv
module tb_dtw_wrap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = 4'hF;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic [1:0]  irq_ch;
  logic        irq_comb;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  dtw_wrap dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq_ch(irq_ch), .irq_comb(irq_comb)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; pstrb = s;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pstrb = 4'hF;
  endtask

  task automatic apb_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compares read data in the access phase and the response signals (R11)
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (psel && penable) begin
        check("R11 ready/err", {30'd0, pready, pslverr}, 32'h2);
        if (!pwrite) begin
          if (sb_q.size() == 0) begin
            check("scoreboard underflow", 32'd1, 32'd0);
          end else begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, prdata, it.exp);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  localparam logic [7:0] ID_EXP [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8,
                                         8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  initial begin
    int waited;
    idle(3);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 irq_ch after reset", {30'd0, irq_ch}, 32'd0);
    check("R10 irq_comb after reset", {31'd0, irq_comb}, 32'd0);
    apb_rd(12'hF00, 32'd0, "R10 test ctrl reset");
    // R3 / R4 reset values
    apb_rd(12'h008, 32'h20, "R3 ch0 ctrl reset");
    apb_rd(12'h028, 32'h20, "R3 ch1 ctrl reset");
    apb_rd(12'h004, 32'hFFFF_FFFF, "R4 ch0 count reset");
    apb_rd(12'h000, 32'h0, "R4 ch0 reload reset");
    // R2 load vs background load
    apb_wr(12'h020, 32'h0000_1234);
    apb_rd(12'h024, 32'h1234, "R2 load sets count");
    apb_rd(12'h020, 32'h1234, "R2 load readback");
    apb_rd(12'h038, 32'h1234, "R1 bgload reads reload");
    apb_wr(12'h038, 32'h0000_ABCD);
    apb_rd(12'h024, 32'h1234, "R2 bgload keeps count");
    apb_rd(12'h020, 32'hABCD, "R2 bgload sets reload");
    apb_rd(12'h02C, 32'h0, "R1 iclr reads zero");
    // R9 strobes ignored
    apb_wr(12'h018, 32'hDEAD_BEEF, 4'b0001);
    apb_rd(12'h000, 32'hDEAD_BEEF, "R9 strobe ignored full word");
    apb_rd(12'h004, 32'hFFFF_FFFF, "R1 ch0 count untouched by ch1/bg");
    // R3 control masking
    apb_wr(12'h028, 32'hFFFF_FF1E);
    apb_rd(12'h028, 32'h0, "R3 undefined ctrl bits read zero");
    apb_wr(12'h028, 32'h21);
    apb_rd(12'h028, 32'h21, "R3 oneshot+ien stored");
    apb_wr(12'h028, 32'h20);
    // R8 unmapped
    apb_rd(12'h01C, 32'h0, "R8 read ch hole");
    apb_rd(12'h040, 32'h0, "R8 read ch index 2");
    apb_rd(12'hF08, 32'h0, "R8 read sys hole");
    apb_rd(12'hF04, 32'h0, "R5 test out reads zero");
    apb_wr(12'h040, 32'hFFFF_FFFF);
    apb_wr(12'h05C, 32'hFFFF_FFFF);
    apb_wr(12'h03C, 32'hFFFF_FFFF);
    apb_wr(12'hF08, 32'hFFFF_FFFF);
    apb_wr(12'hFD0, 32'hFFFF_FFFF);
    apb_rd(12'h000, 32'hDEAD_BEEF, "R8 ch0 reload intact");
    apb_rd(12'h020, 32'hABCD, "R8 ch1 reload intact");
    apb_rd(12'h028, 32'h20, "R8 ch1 ctrl intact");
    apb_rd(12'hF00, 32'h0, "R8 test ctrl intact");
    apb_rd(12'hFD0, 32'h04, "R8 id intact");
    check("R8 irq after stray writes", {30'd0, irq_ch}, 32'd0);
    // R7 identification window
    for (int k = 0; k < 12; k++)
      apb_rd(12'hFD0 + 12'(4 * k), {24'd0, ID_EXP[k]}, $sformatf("R7 id word %0d", k));
    // R5 / R6 test override
    apb_wr(12'hF00, 32'h1);
    apb_rd(12'hF00, 32'h1, "R5 test ctrl readback");
    apb_wr(12'hF04, 32'h2);
    idle(2);
    check("R5 test drives ch1 only", {30'd0, irq_ch}, 32'h2);
    check("R6 comb with ch1", {31'd0, irq_comb}, 32'h1);
    apb_wr(12'hF04, 32'h1);
    idle(2);
    check("R5 test drives ch0 only", {30'd0, irq_ch}, 32'h1);
    apb_wr(12'hF04, 32'h0);
    idle(2);
    check("R6 comb low", {31'd0, irq_comb}, 32'h0);
    apb_wr(12'hF04, 32'h3);
    apb_wr(12'hF00, 32'h0);
    idle(2);
    check("R10 normal mode ignores test out", {30'd0, irq_ch}, 32'h0);
    // R4 channel interrupt path
    apb_wr(12'h000, 32'd5);
    apb_wr(12'h008, 32'hE0);
    waited = 0;
    while (irq_ch[0] !== 1'b1 && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    check("R4 ch0 irq raised", {31'd0, irq_ch[0]}, 32'h1);
    check("R6 comb follows ch0", {31'd0, irq_comb}, 32'h1);
    check("R1 ch1 irq stays low", {31'd0, irq_ch[1]}, 32'h0);
    apb_wr(12'h008, 32'h20);
    apb_rd(12'h010, 32'h1, "R4 raw set");
    apb_rd(12'h014, 32'h1, "R4 masked set");
    apb_wr(12'h008, 32'h00);
    apb_rd(12'h014, 32'h0, "R4 masked off when ien=0");
    apb_rd(12'h010, 32'h1, "R4 raw held");
    idle(1);
    check("R10 irq follows masked status", {31'd0, irq_ch[0]}, 32'h0);
    apb_wr(12'h00C, 32'h0);
    apb_rd(12'h010, 32'h0, "R4 iclr clears raw");
    idle(4);
    wait (sb_q.size() == 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule